// File: doc/BRIEF.md
# Memory Card Answer-to-Reset Sequencer

This block is the card-side logic that produces the answer-to-reset bit stream of a synchronous serial memory card. The card reset and card clock lines are asynchronous to the system clock. Each line passes through a two-flop synchroniser, and its edges are detected in the system clock domain. The block drives a read address into a small byte memory and a tri-stateable serial data bit, given as a value plus an output enable.

A card clock pulse while card reset is high arms the sequence and clears the bit counter. When card reset then falls, bit 0 of byte 0 is driven. Each later card clock pulse advances the stream by one bit. Bits go out least significant first, and bytes go out in rising address order. The clock pulse after the last bit of byte 3 releases the line and raises a done flag, which hands the card over to a command receiver. A new card reset restarts the sequence at any point.

Top module: `atr_sequencer`

## Requirements
- R1: After system reset, io_oe_o and done_o are 0.
- R2: A card clock rising edge while card_rst_i is high, followed by card_rst_i falling, sets io_oe_o to 1 with mem_addr_o equal to 0 and io_o equal to bit 0 of byte 0.
- R3: Each card clock rising edge after the reset fall advances the stream. Stream bit n (n = 0..31) equals bit (n mod 8) of the byte at address (n div 8), and mem_addr_o equals n div 8 while bit n is driven.
- R4: The 32nd card clock rising edge after the reset fall (the 33rd pulse overall) sets io_oe_o to 0 and done_o to 1.
- R5: Once done_o is 1, it stays 1 and io_oe_o stays 0 across further card clock pulses, until card_rst_i rises.
- R6: A rise of card_rst_i at any point, including mid-stream, sets io_oe_o and done_o to 0. A following clock pulse and reset fall restart the stream at bit 0.
- R7: A fall of card_rst_i with no card clock rising edge since its rise leaves io_oe_o at 0 and done_o at 0, and later clock pulses drive nothing.
- R8: The outputs respond at the third system clock rising edge after a card line change, and not before.
- R9: io_o is 0 whenever io_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| card_rst_i | input | 1 | Card reset line, asynchronous |
| card_clk_i | input | 1 | Card clock line, asynchronous |
| mem_addr_o | output | ADDR_W | Byte address into card memory |
| mem_data_i | input | 8 | Byte read from mem_addr_o, combinational |
| io_o | output | 1 | Serial data value |
| io_oe_o | output | 1 | Output enable; 0 means high impedance |
| done_o | output | 1 | Answer-to-reset finished |

## Verification
A bit counter that is off by one shows up as a wrong bit on io_o within one card clock pulse. It also moves the tri-state point one pulse early or late, and that is visible at io_oe_o and done_o. A wrong state after an aborted stream shows as a stream that does not restart at bit 0 of byte 0, or as io_oe_o staying high after card_rst_i rises. The synchroniser depth can be seen directly as the number of system clock edges before each response.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SHIFT,
    ST_DONE
  } atr_state_e;
endpackage

// File: rtl/atr_edge_sync.sv
module atr_edge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign lvl_o = stage_q[STAGES-1];
  assign chg_o = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
#(
  parameter int NBITS = 32,
  parameter int CNT_W = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_lvl_i,
  input  logic             rst_chg_i,
  input  logic             clk_lvl_i,
  input  logic             clk_chg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             oe_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  atr_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic oe_q, done_q;
  logic rst_rise, rst_fall, clk_rise;

  assign rst_rise = rst_chg_i & rst_lvl_i;
  assign rst_fall = rst_chg_i & ~rst_lvl_i;
  assign clk_rise = clk_chg_i & clk_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (rst_rise) begin
      // abort wherever we are
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rst_lvl_i && clk_rise) begin
          state_q <= ST_ARMED;
          cnt_q   <= '0;
        end
        ST_ARMED: if (rst_fall) begin
          state_q <= ST_SHIFT;
          oe_q    <= 1'b1;
        end
        ST_SHIFT: if (clk_rise) begin
          if (cnt_q == LAST) begin
            state_q <= ST_DONE;
            oe_q    <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign oe_o   = oe_q;
  assign done_o = done_q;

  // R2
  start_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && rst_fall && !rst_rise) |=> (oe_q && cnt_q == '0));
  // R3
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && clk_rise && !rst_rise && cnt_q != LAST) |=> (oe_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && oe_q));
  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rst_rise) |=> done_q);
  // R6
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rise |=> (!oe_q && !done_q && cnt_q == '0));
endmodule

// File: rtl/atr_sequencer.sv
module atr_sequencer #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ATR_BYTES = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_rst_i,
  input  logic              card_clk_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              io_o,
  output logic              io_oe_o,
  output logic              done_o
);
  localparam int NBITS = ATR_BYTES * DATA_W;
  localparam int CNT_W = $clog2(NBITS);
  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0] lvl, chg;
  logic [CNT_W-1:0] cnt;
  logic oe;

  atr_edge_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({card_rst_i, card_clk_i}),
    .lvl_o   (lvl),
    .chg_o   (chg)
  );

  atr_ctrl #(.NBITS(NBITS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_lvl_i (lvl[1]),
    .rst_chg_i (chg[1]),
    .clk_lvl_i (lvl[0]),
    .clk_chg_i (chg[0]),
    .cnt_o     (cnt),
    .oe_o      (oe),
    .done_o    (done_o)
  );

  assign mem_addr_o = ADDR_W'(cnt >> BIT_W);
  assign io_o       = oe & mem_data_i[cnt[BIT_W-1:0]];
  assign io_oe_o    = oe;
endmodule

// File: tb/atr_sequencer_bench.sv
module atr_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 0, rst_n = 0, card_rst = 0, card_clk = 0;
  logic [7:0] addr, mdata;
  logic io, io_oe, done;
  logic [7:0] mem [4];
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mdata = (addr < 8'd4) ? mem[addr[1:0]] : 8'h00;

  atr_sequencer u_atr_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .card_rst_i(card_rst), .card_clk_i(card_clk),
    .mem_addr_o(addr), .mem_data_i(mdata), .io_o(io), .io_oe_o(io_oe), .done_o(done)
  );

  function automatic logic exp_bit(int n);
    return mem[n/8][n%8];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); card_clk = 1; settle();
    card_clk = 0; settle();
  endtask

  task automatic check_idle(input string tag, input bit exp_done);
    chk(io_oe == 0, tag, io_oe, 0);
    chk(done == exp_done, tag, done, exp_done);
    chk(io == 0, "R9 io low when released", io, 0);
  endtask

  task automatic start_atr(input bit fine_timing);
    @(negedge clk); card_rst = 1; settle();
    pulse();
    card_rst = 0;
    if (fine_timing) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(io_oe == 0, "R8 no response before third edge", io_oe, 0);
      @(posedge clk); @(negedge clk);
      chk(io_oe == 1, "R8 response at third edge", io_oe, 1);
    end
    settle();
    chk(io_oe == 1, "R2 enable after reset fall", io_oe, 1);
    chk(addr == 0, "R2 address zero", addr, 0);
    chk(io == exp_bit(0), "R2 first bit", io, exp_bit(0));
  endtask

  task automatic full_atr(input bit fine_timing);
    start_atr(fine_timing);
    for (int n = 1; n < 32; n++) begin
      pulse();
      chk(io_oe == 1 && io == exp_bit(n), $sformatf("R3 bit %0d", n), {io_oe, io}, {1'b1, exp_bit(n)});
      chk(addr == n/8, $sformatf("R3 addr at bit %0d", n), addr, n/8);
    end
    pulse();
    check_idle("R4 release after 33rd pulse", 1);
    for (int k = 0; k < 3; k++) begin
      pulse();
      check_idle("R5 done held", 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4432));
    for (int i = 0; i < 4; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state", 0);
    rst_n = 1;
    settle();
    check_idle("R1 after reset release", 0);

    // directed patterns
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h01; mem[3] = 8'h80;
    full_atr(1);
    mem[0] = 8'hFF; mem[1] = 8'h00; mem[2] = 8'hFF; mem[3] = 8'h00;
    full_atr(0);

    // random contents
    for (int it = 0; it < 3; it++) begin
      for (int i = 0; i < 4; i++) mem[i] = 8'($urandom);
      full_atr(0);
    end

    // abort mid-stream at random points, including bit 31
    for (int it = 0; it < 3; it++) begin
      int stop_at;
      stop_at = (it == 2) ? 31 : int'($urandom_range(1, 30));
      for (int i = 0; i < 4; i++) mem[i] = 8'($urandom);
      start_atr(0);
      for (int n = 1; n <= stop_at; n++) pulse();
      @(negedge clk); card_rst = 1; settle();
      check_idle($sformatf("R6 abort at bit %0d", stop_at), 0);
      full_atr(0);
    end

    // reset fall without clock pulse
    @(negedge clk); card_rst = 1; settle();
    card_rst = 0; settle();
    check_idle("R7 no clock during reset", 0);
    pulse(); pulse();
    check_idle("R7 clocks drive nothing", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule